// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a serial-peripheral master controlled through a small 32-bit register port. Software writes a command word that picks the clock mode (CPOL/CPHA), one of four chip selects, bit order, transmit and receive enables and a transfer length of 1 to 32 bits. Setting the start bit launches exactly one word transfer. Transmit words come from a 4-deep TX FIFO written through a data port. Received words are packed right-aligned into a 4-deep RX FIFO that software reads through a second data port.

Completion is reported by a ready flag that stays set until software clears it. FIFO fill levels and four sticky error flags (RX underrun, RX overflow, TX underrun, TX overflow) sit in a status register. Software clears the error flags by writing ones, so writing back a value it just read clears exactly the flags it saw. A chip select is normally asserted by hardware for the length of a transfer. Software can instead take control of it and hold it low across several transfers.

Register word addresses: 0 command, 1 transfer status, 2 FIFO status, 3 TX data port (write), 4 RX data port (read). Reads are combinational from `bus_addr`. A read of the RX port pops the FIFO at the clock edge.

Top module: `spi_regmaster`

## Requirements
- R1: After reset the chip selects are all high, SCLK and MOSI are low, the command and transfer status registers read 0, and the FIFO status reads 0x005 (bit 0 RX empty, bit 2 TX empty).
- R2: The command register keeps and reads back the writable fields: bit 30 master select, bits 29:28 mode (bit 29 CPOL, bit 28 CPHA), bits 27:26 chip-select index, bit 21 software CS enable, bit 20 software CS level, bit 16 LSB first, bit 15 byte order, bit 12 RX enable, bit 11 TX enable, bits 4:0 length minus one. All other bits, and the start bit 31, read 0.
- R3: Writing the command with bit 31 set, while idle, shifts length+1 bits MSB first in the mode given. SCLK idles at CPOL. Data is launched on the leading or trailing edge and sampled on the other, as in SPI modes 0 to 3. The MISO bits are packed right-aligned, with the first bit received at bit position length.
- R4: With bit 16 set, the TX word is sent from bit 0 upward, and the n-th received bit lands at bit position n.
- R5: Transfer status bit 30 is set when a transfer completes and is cleared by writing 1 to bit 30.
- R6: In hardware CS mode (bit 21 = 0), only the chip select picked by bits 27:26 is low, and only while a transfer runs. At most one chip select is ever low.
- R7: In software CS mode (bit 21 = 1), the selected chip select follows bit 20 (0 = low, 1 = high), independent of transfers.
- R8: A write to the TX port while the TX FIFO holds 4 words sets TX overflow (bit 7) and drops the word. Bit 3 flags the TX FIFO as full.
- R9: A read of the RX port while the RX FIFO is empty returns 0 and sets RX underrun (bit 4). A transfer that completes while the RX FIFO is full (bit 1) sets RX overflow (bit 5) and drops its word.
- R10: A start with TX enabled and an empty TX FIFO shifts out zeros and sets TX underrun (bit 6).
- R11: FIFO status bit 8 is set while any of bits 7:4 is set. Writing 1 to any of bits 7:4 clears that flag, and writing 0 leaves it unchanged.
- R12: With TX disabled, MOSI stays low and the TX FIFO is not popped. With RX disabled, nothing is pushed into the RX FIFO.
- R13: A start request written while a transfer is running is ignored: no TX word is popped and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the RX port) |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Active-low chip selects |

## Verification
The bench acts as an SPI slave. It drives MISO bit by bit and collects MOSI on the sample edge of each of the four modes, at lengths of 1, 8, 13 and 32 bits and in both bit orders. A wrong edge choice or packing shows up as a shifted or reversed word. It fills the TX FIFO past four and the RX FIFO past four, and reads the RX FIFO empty. A design that overwrote stored words or failed to set the sticky flags would return the wrong data or a wrong status word. It also issues a start during a busy transfer, starts with an empty FIFO, and disables each direction. Consuming the pending TX word or launching a second transfer would leave a wrong FIFO status or a stray ready flag.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;
  localparam logic [2:0] ADDR_CMD  = 3'd0;
  localparam logic [2:0] ADDR_XST  = 3'd1;
  localparam logic [2:0] ADDR_FST  = 3'd2;
  localparam logic [2:0] ADDR_TXD  = 3'd3;
  localparam logic [2:0] ADDR_RXD  = 3'd4;

  localparam int B_GO      = 31;
  localparam int B_CPOL    = 29;
  localparam int B_CPHA    = 28;
  localparam int B_SWCS    = 21;
  localparam int B_CSLVL   = 20;
  localparam int B_LSB     = 16;
  localparam int B_RXEN    = 12;
  localparam int B_TXEN    = 11;
  localparam int B_READY   = 30;

  localparam logic [31:0] CMD_WMASK = 32'h7C31_981F;

  typedef struct packed {
    logic [4:0] len;
    logic       cpol;
    logic       cpha;
    logic       lsb;
    logic       rx_en;
  } xfer_cfg_t;
endpackage

// File: rtl/spi_rm_fifo.sv
module spi_rm_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wr_q, wr_d, rd_q, rd_d;

  assign empty = (wr_q == rd_q);
  assign full  = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
  assign head  = mem[rd_q[AW-1:0]];

  always_comb begin
    wr_d = wr_q;
    rd_d = rd_q;
    if (push) wr_d = wr_q + 1'b1;
    if (pop)  rd_d = rd_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q[AW-1:0]] <= din;
  end
endmodule

// File: rtl/spi_rm_engine.sv
module spi_rm_engine
  import spi_rm_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  xfer_cfg_t   cfg,
  input  logic [31:0] tx_word,
  input  logic        miso,
  output logic        busy,
  output logic        sclk,
  output logic        mosi,
  output logic        done,
  output logic        done_rx,
  output logic [31:0] rx_word
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(HALF - 1);

  logic            busy_q, busy_d, sclk_q, sclk_d, mosi_q, mosi_d, done_q, done_d;
  logic [CW-1:0]   div_q, div_d;
  logic [5:0]      half_q, half_d;
  logic [31:0]     tx_q, tx_d, rx_q, rx_d, rxw_q, rxw_d, tx_align, tx_next;
  xfer_cfg_t       cfg_q, cfg_d;

  always_comb begin
    busy_d = busy_q; sclk_d = sclk_q; mosi_d = mosi_q; done_d = 1'b0;
    div_d  = div_q;  half_d = half_q; tx_d = tx_q; rx_d = rx_q;
    rxw_d  = rxw_q;  cfg_d  = cfg_q;
    tx_align = cfg.lsb ? tx_word : (tx_word << (5'd31 - cfg.len));
    tx_next  = cfg_q.lsb ? (tx_q >> 1) : (tx_q << 1);
    if (start && !busy_q) begin
      busy_d = 1'b1;
      cfg_d  = cfg;
      div_d  = '0;
      half_d = '0;
      tx_d   = tx_align;
      mosi_d = cfg.lsb ? tx_align[0] : tx_align[31];
      rx_d   = '0;
      sclk_d = cfg.cpol ^ cfg.cpha;
    end else if (busy_q) begin
      if (div_q == DIV_LAST) begin
        div_d = '0;
        if (half_q == {cfg_q.len, 1'b1}) begin
          busy_d = 1'b0;
          done_d = 1'b1;
          mosi_d = 1'b0;
          sclk_d = cfg_q.cpol;
          rxw_d  = cfg_q.lsb ? (rx_q >> (5'd31 - cfg_q.len)) : rx_q;
        end else begin
          half_d = half_q + 6'd1;
          sclk_d = cfg_q.cpol ^ cfg_q.cpha ^ ~half_q[0];
          if (!half_q[0]) begin
            rx_d = cfg_q.lsb ? {miso, rx_q[31:1]} : {rx_q[30:0], miso};
          end else begin
            tx_d   = tx_next;
            mosi_d = cfg_q.lsb ? tx_next[0] : tx_next[31];
          end
        end
      end else begin
        div_d = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; sclk_q <= 1'b0; mosi_q <= 1'b0; done_q <= 1'b0;
      div_q  <= '0;   half_q <= '0;   tx_q   <= '0;   rx_q   <= '0;
      rxw_q  <= '0;   cfg_q  <= '0;
    end else begin
      busy_q <= busy_d; sclk_q <= sclk_d; mosi_q <= mosi_d; done_q <= done_d;
      div_q  <= div_d;  half_q <= half_d; tx_q   <= tx_d;   rx_q   <= rx_d;
      rxw_q  <= rxw_d;  cfg_q  <= cfg_d;
    end
  end

  assign busy    = busy_q;
  assign sclk    = sclk_q;
  assign mosi    = mosi_q;
  assign done    = done_q;
  assign done_rx = done_q && cfg_q.rx_en;
  assign rx_word = rxw_q;
endmodule

// File: rtl/spi_regmaster.sv
module spi_regmaster
  import spi_rm_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic [3:0]  spi_cs_n
);
  localparam int NUM_CS = 4;

  logic [1:0]  rst_pipe;
  logic        rst_q_n;
  logic [31:0] cmd_q, cmd_d;
  logic        ready_q, ready_d;
  logic [3:0]  flag_q, flag_d, flag_set, flag_clr;
  logic        go_req, start, tx_wr, tx_push, tx_pop, rx_rd, rx_pop, rx_push;
  logic        tx_empty, tx_full, rx_empty, rx_full;
  logic [31:0] tx_head, rx_head, tx_word, rx_word;
  logic        eng_busy, eng_sclk, eng_done, eng_done_rx, cs_active;
  xfer_cfg_t   start_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  assign go_req  = bus_wr && (bus_addr == ADDR_CMD) && bus_wdata[B_GO];
  assign start   = go_req && !eng_busy;
  assign tx_wr   = bus_wr && (bus_addr == ADDR_TXD);
  assign tx_push = tx_wr && !tx_full;
  assign tx_pop  = start && bus_wdata[B_TXEN] && !tx_empty;
  assign rx_rd   = bus_rd && (bus_addr == ADDR_RXD);
  assign rx_pop  = rx_rd && !rx_empty;
  assign rx_push = eng_done_rx && !rx_full;
  assign tx_word = tx_pop ? tx_head : 32'd0;

  assign start_cfg.len   = bus_wdata[4:0];
  assign start_cfg.cpol  = bus_wdata[B_CPOL];
  assign start_cfg.cpha  = bus_wdata[B_CPHA];
  assign start_cfg.lsb   = bus_wdata[B_LSB];
  assign start_cfg.rx_en = bus_wdata[B_RXEN];

  // flag order {tx_ovf, tx_unr, rx_ovf, rx_unr} = FIFO status bits 7:4
  always_comb begin
    flag_set = {tx_wr && tx_full,
                start && bus_wdata[B_TXEN] && tx_empty,
                eng_done_rx && rx_full,
                rx_rd && rx_empty};
    flag_clr = (bus_wr && (bus_addr == ADDR_FST)) ? bus_wdata[7:4] : 4'd0;
    flag_d   = (flag_q & ~flag_clr) | flag_set;
    ready_d  = eng_done ||
               (ready_q && !(bus_wr && (bus_addr == ADDR_XST) && bus_wdata[B_READY]));
    cmd_d    = cmd_q;
    if (bus_wr && (bus_addr == ADDR_CMD)) cmd_d = bus_wdata & CMD_WMASK;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cmd_q   <= '0;
      ready_q <= 1'b0;
      flag_q  <= '0;
    end else begin
      cmd_q   <= cmd_d;
      ready_q <= ready_d;
      flag_q  <= flag_d;
    end
  end

  spi_rm_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_q_n), .push(tx_push), .pop(tx_pop), .din(bus_wdata),
    .head(tx_head), .empty(tx_empty), .full(tx_full));

  spi_rm_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_q_n), .push(rx_push), .pop(rx_pop), .din(rx_word),
    .head(rx_head), .empty(rx_empty), .full(rx_full));

  spi_rm_engine #(.CLK_DIV(CLK_DIV)) u_eng (
    .clk(clk), .rst_n(rst_q_n), .start(start), .cfg(start_cfg), .tx_word(tx_word),
    .miso(spi_miso), .busy(eng_busy), .sclk(eng_sclk), .mosi(spi_mosi),
    .done(eng_done), .done_rx(eng_done_rx), .rx_word(rx_word));

  assign spi_sclk  = eng_busy ? eng_sclk : cmd_q[B_CPOL];
  assign cs_active = cmd_q[B_SWCS] ? !cmd_q[B_CSLVL] : eng_busy;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign spi_cs_n[i] = !(cs_active && (cmd_q[27:26] == 2'(i)));
  end

  always_comb begin
    case (bus_addr)
      ADDR_CMD: bus_rdata = cmd_q;
      ADDR_XST: bus_rdata = {1'b0, ready_q, 30'd0};
      ADDR_FST: bus_rdata = {23'd0, |flag_q, flag_q, tx_full, tx_empty, rx_full, rx_empty};
      ADDR_RXD: bus_rdata = rx_empty ? 32'd0 : rx_head;
      default:  bus_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/spi_regmaster_chk.sv
module spi_regmaster_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [2:0]  bus_addr,
  input logic        busy,
  input logic        done,
  input logic        ready,
  input logic        tx_full,
  input logic        rx_empty,
  input logic        tx_ovf,
  input logic        rx_unr,
  input logic        sclk,
  input logic        mosi,
  input logic        sw_cs,
  input logic [31:0] cmd,
  input logic [3:0]  cs_n
);
  a_r6_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  a_r6_hw_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !sw_cs) |-> (cs_n == 4'hF));

  a_r3_mosi_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mosi);

  a_r3_sclk_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $stable(cmd)) |-> $stable(sclk));

  a_r5_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ready);

  a_r8_tx_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd3 && tx_full) |=> tx_ovf);

  a_r9_rx_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd4 && rx_empty) |=> rx_unr);
endmodule

bind spi_regmaster spi_regmaster_chk u_chk (
  .clk(clk), .rst_n(rst_q_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .busy(eng_busy), .done(eng_done), .ready(ready_q), .tx_full(tx_full),
  .rx_empty(rx_empty), .tx_ovf(flag_q[3]), .rx_unr(flag_q[0]), .sclk(spi_sclk),
  .mosi(spi_mosi), .sw_cs(cmd_q[21]), .cmd(cmd_q), .cs_n(spi_cs_n));

// File: tb/spi_regmaster_bench.sv
`timescale 1ns/1ps
module spi_regmaster_bench;
  localparam logic [2:0] A_CMD = 3'd0, A_XST = 3'd1, A_FST = 3'd2, A_TX = 3'd3, A_RX = 3'd4;

  logic        clk, rst_n, bus_wr, bus_rd, spi_sclk, spi_mosi, spi_miso;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0]  spi_cs_n;
  int checks = 0, fails = 0;
  bit finished = 0;

  spi_regmaster u_spi_regmaster (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  function automatic logic [31:0] mkcmd(input bit go, input logic [1:0] mode, input logic [1:0] idx,
      input bit sw, input bit lvl, input bit lsb, input bit rxe, input bit txe, input logic [4:0] len);
    return {go, 1'b1, mode, idx, 4'd0, sw, lvl, 3'd0, lsb, 3'd0, rxe, txe, 6'd0, len};
  endfunction

  function automatic logic [31:0] lmask(input logic [4:0] len);
    return 32'hFFFF_FFFF >> (5'd31 - len);
  endfunction

  function automatic logic [31:0] exp_rx(input logic [4:0] len, input bit lsb, input logic [31:0] w);
    logic [31:0] r = '0;
    for (int k = 0; k <= int'(len); k++) begin
      if (lsb) r[k] = w[int'(len) - k];
      else     r[int'(len) - k] = w[int'(len) - k];
    end
    return r;
  endfunction

  task automatic wait_ready(input string req);
    logic [31:0] d = '0;
    for (int n = 0; n < 300; n++) begin
      rd(A_XST, d);
      if (d[30]) break;
    end
    check("R5", "ready set after transfer", d, 32'h4000_0000);
    wr(A_XST, 32'h4000_0000);
    rd(A_XST, d);
    check("R5", "ready cleared by write one", d, 32'h0);
    if (req == "") ;
  endtask

  task automatic xfer(input logic [1:0] mode, input logic [1:0] idx, input logic [4:0] len,
      input bit lsb, input logic [31:0] txw, input logic [31:0] misow, input bit wr_tx,
      input bit rd_rx, input bit txe, input bit rxe, input bit sw, input string tag);
    logic [31:0] mo = '0, d, e;
    bit rise = (mode[1] == mode[0]);
    if (wr_tx) wr(A_TX, txw);
    spi_miso = misow[len];
    wr(A_CMD, mkcmd(1'b1, mode, idx, sw, 1'b0, lsb, rxe, txe, len));
    for (int k = 0; k <= int'(len); k++) begin
      if (rise) @(posedge spi_sclk); else @(negedge spi_sclk);
      if (lsb) mo[k] = spi_mosi; else mo = {mo[30:0], spi_mosi};
      if (k == 0) check("R6", "selected cs low in transfer", {28'd0, spi_cs_n}, {28'd0, ~(4'b1 << idx)});
      #1;
      if (k < int'(len)) spi_miso = misow[int'(len) - k - 1];
    end
    wait_ready(tag);
    e = txe ? (txw & lmask(len)) : 32'd0;
    check(tag, "mosi word", mo, e);
    check("R3", "sclk idles at cpol", {31'd0, spi_sclk}, {31'd0, mode[1]});
    if (!sw) check("R6", "cs released after transfer", {28'd0, spi_cs_n}, 32'hF);
    if (rd_rx) begin
      rd(A_RX, d);
      check(tag, "received word", d, exp_rx(len, lsb, misow));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R13 watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, w[5];
    void'($urandom(32'd2024));
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0; spi_miso = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1", "cs_n", {28'd0, spi_cs_n}, 32'hF);
    check("R1", "sclk/mosi", {30'd0, spi_sclk, spi_mosi}, 32'd0);
    rd(A_CMD, d); check("R1", "command", d, 32'd0);
    rd(A_XST, d); check("R1", "xfer status", d, 32'd0);
    rd(A_FST, d); check("R1", "fifo status", d, 32'h005);

    // R2 readback
    wr(A_CMD, 32'h7FFF_FFFF);
    rd(A_CMD, d); check("R2", "command readback", d, 32'h7C31_981F);
    check("R7", "sw cs level 1 releases", {28'd0, spi_cs_n}, 32'hF);
    wr(A_CMD, 32'd0);
    rd(A_CMD, d); check("R2", "command cleared", d, 32'd0);

    // R7 software chip select
    wr(A_CMD, mkcmd(1'b0, 2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd7));
    check("R7", "sw cs asserted idx2", {28'd0, spi_cs_n}, 32'hB);
    wr(A_CMD, mkcmd(1'b0, 2'd0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd7));
    check("R7", "sw cs released", {28'd0, spi_cs_n}, 32'hF);
    xfer(2'd0, 2'd1, 5'd7, 1'b0, 32'hA5, 32'h3C, 1, 1, 1, 1, 1, "R7");
    check("R7", "sw cs held after transfer", {28'd0, spi_cs_n}, 32'hD);
    wr(A_CMD, 32'd0);
    check("R7", "cs released on command", {28'd0, spi_cs_n}, 32'hF);
    rd(A_CMD, d); check("R2", "go bit reads zero", d[31], 1'b0);

    // R3 all modes, R4 lsb first
    for (int m = 0; m < 4; m++)
      xfer(2'(m), 2'(m), 5'd7, 1'b0, 32'hC3 ^ m, 32'h5A + m, 1, 1, 1, 1, 0, "R3");
    xfer(2'd0, 2'd0, 5'd31, 1'b0, 32'hDEAD_BEEF, 32'h1234_5678, 1, 1, 1, 1, 0, "R3");
    xfer(2'd3, 2'd1, 5'd0, 1'b0, 32'h1, 32'h1, 1, 1, 1, 1, 0, "R3");
    xfer(2'd1, 2'd2, 5'd12, 1'b1, 32'h0ABC, 32'h1357, 1, 1, 1, 1, 0, "R4");
    xfer(2'd2, 2'd3, 5'd31, 1'b1, 32'h8000_0001, 32'hF0F0_1234, 1, 1, 1, 1, 0, "R4");
    wr(A_CMD, mkcmd(1'b0, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd7));
    check("R3", "idle sclk follows cpol", {31'd0, spi_sclk}, 32'd1);

    // R8 tx overflow, R11 w1c
    for (int i = 0; i < 5; i++) begin w[i] = $urandom; wr(A_TX, w[i]); end
    rd(A_FST, d); check("R8", "tx full + overflow + err", d, 32'h189);
    wr(A_FST, 32'h0);
    rd(A_FST, d); check("R11", "write zero keeps flags", d, 32'h189);
    wr(A_FST, d);
    rd(A_FST, d); check("R11", "write back clears flags", d, 32'h009);
    for (int i = 0; i < 4; i++)
      xfer(2'd0, 2'd0, 5'd31, 1'b0, w[i], 32'h0, 0, 1, 1, 1, 0, "R8");
    rd(A_FST, d); check("R8", "fifo drained, fifth dropped", d, 32'h005);

    // R10 tx underrun
    xfer(2'd1, 2'd0, 5'd15, 1'b0, 32'h0, 32'hBEEF, 0, 1, 1, 1, 0, "R10");
    rd(A_FST, d); check("R10", "tx underrun flag", d, 32'h145);
    wr(A_FST, 32'h1F0);

    // R9 rx underrun and overflow
    rd(A_RX, d); check("R9", "empty rx read value", d, 32'd0);
    rd(A_FST, d); check("R9", "rx underrun flag", d, 32'h115);
    wr(A_FST, 32'h1F0);
    for (int i = 0; i < 5; i++) begin
      w[i] = $urandom;
      xfer(2'd0, 2'd0, 5'd15, 1'b0, 32'h1111 * i, w[i], 1, 0, 1, 1, 0, "R9");
    end
    rd(A_FST, d); check("R9", "rx full + overflow", d, 32'h126);
    for (int i = 0; i < 4; i++) begin
      rd(A_RX, d); check("R9", "stored rx word", d, w[i] & 32'hFFFF);
    end
    rd(A_FST, d); check("R11", "err stays until cleared", d, 32'h125);
    wr(A_FST, 32'h1F0);

    // R12 direction disables
    wr(A_TX, 32'h0000_00E7);
    xfer(2'd0, 2'd0, 5'd7, 1'b0, 32'hE7, 32'hFF, 0, 0, 0, 0, 0, "R12");
    rd(A_FST, d); check("R12", "tx kept, rx not pushed", d, 32'h001);
    xfer(2'd0, 2'd0, 5'd7, 1'b0, 32'hE7, 32'h81, 0, 1, 1, 1, 0, "R12");

    // R13 start while busy ignored
    wr(A_TX, 32'hCAFE_0001);
    wr(A_TX, 32'h0BAD_F00D);
    wr(A_CMD, mkcmd(1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd31));
    wr(A_CMD, mkcmd(1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd31));
    wait_ready("R13");
    rd(A_FST, d); check("R13", "second word still queued", d, 32'h001);
    repeat (300) @(negedge clk);
    rd(A_XST, d); check("R13", "no second transfer", d, 32'd0);
    xfer(2'd0, 2'd0, 5'd31, 1'b0, 32'h0BAD_F00D, 32'h0, 0, 1, 1, 1, 0, "R13");

    // random mix
    for (int i = 0; i < 24; i++) begin
      logic [1:0] md = 2'($urandom % 4);
      logic [4:0] ln = 5'($urandom % 32);
      bit ls = bit'($urandom % 2);
      xfer(md, 2'($urandom % 4), ln, ls, $urandom, $urandom, 1, 1, 1, 1, 0, ls ? "R4" : "R3");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule